// File: doc/BRIEF.md
# PTP Event Frame Detector and Timestamper

This block sits on one direction of a byte-wide Ethernet frame stream and picks out the frames that carry a precision time protocol (IEEE 1588v2) event message. A chip uses two copies of it. The transmit copy watches frames heading out to the media. The receive copy watches frames coming in from the line. The stream starts at the destination MAC address, on the byte that follows the start-of-frame delimiter. The parser walks through the encapsulation layers one byte at a time. It accepts PTP carried directly on layer 2, behind zero, one or two VLAN tags. It also accepts PTP in UDP over IPv4 or IPv6, where the IP packet may sit behind a PPPoE session header or behind an LLC/SNAP header.

On the first byte of every frame, the block latches a free-running time-of-day value made of 48-bit seconds and 32-bit nanoseconds. It then corrects that value by a programmable fixed latency. The transmit copy adds the latency so that the stamp reflects the moment the frame reaches the media. The receive copy subtracts it. When a frame ends cleanly and its parse matched, the block queues one result. The result holds the corrected stamp, the message type and the sequence number, and it leaves through a valid/ready handshake. Frames that do not match, or that end in error, leave no trace.

Top module: `ptp_stamp_unit`

## Requirements
- R1: An untagged frame with EtherType 0x88F7 yields one result. The result type is the low nibble of the first PTP byte. The result sequence number is PTP bytes 30 (high) and 31 (low).
- R2: Layer-2 PTP behind one or two VLAN tags is matched, where each tag is EtherType 0x8100 or 0x88A8 followed by a 2-byte tag field. A frame with a third tag yields no result.
- R3: IPv4 (EtherType 0x0800, version 4) is matched when the protocol byte at header offset 9 is 17 and the UDP destination port is 319. The UDP header starts at 4×IHL bytes, so header options are skipped. Any other destination port yields no result.
- R4: IPv6 (EtherType 0x86DD, version 6) is matched when the next-header byte at offset 6 is 17. The UDP header then starts at byte 40. Any other next-header value yields no result.
- R5: A PPPoE session frame (EtherType 0x8864) has a 6-byte header followed by a 2-byte PPP protocol. That protocol leads to IPv4 when it is 0x0021 and to IPv6 when it is 0x0057.
- R6: A type field below 0x0600 is a length. It must be followed by AA AA 03 00 00 00 and then an EtherType, which is decoded as usual. Any other SNAP byte yields no result.
- R7: Only message types 0 to 3 (the event messages) produce a result. Other types, and frames whose EtherType is none of the above, yield no result.
- R8: The stamp is the time-of-day present on the first byte of the frame, not a later value. Transmit adds the latency input and carries into seconds when nanoseconds reach 10^9. Receive subtracts the latency and borrows a second when needed.
- R9: A frame whose last byte carries the error flag yields no result. A frame that ends before its sequence number has been read also yields no result.
- R10: Up to 4 results are queued in arrival order. While valid is high and ready is low, the head result holds steady.
- R11: A result that arrives when the queue is full is dropped and sets a sticky overflow flag. The flag is cleared only by reset.
- R12: After reset, result valid and the overflow flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_ns | input | 32 | Fixed latency correction in nanoseconds, below 10^9 |
| tod_sec | input | 48 | Free-running seconds count |
| tod_ns | input | 32 | Free-running nanoseconds count, below 10^9 |
| fr_valid | input | 1 | Frame byte present this cycle |
| fr_data | input | 8 | Frame byte |
| fr_sof | input | 1 | Byte is the first one of the frame |
| fr_eof | input | 1 | Byte is the last one of the frame |
| fr_err | input | 1 | Frame is bad; sampled with fr_eof |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_sec | output | 48 | Stamp seconds |
| res_ns | output | 32 | Stamp nanoseconds |
| res_type | output | 4 | Message type |
| res_seq | output | 16 | Sequence number |
| res_ovf | output | 1 | Sticky result-dropped flag |

## Verification
A parser state that has drifted out of step with the bytes does not fail quietly. It either drops a good frame or accepts a bad one, so res_valid is wrong two cycles after the frame's last byte. The encapsulation vectors therefore check for the presence or absence of a result on every frame. A stamp taken on the wrong byte, or a carry or borrow that goes astray, shows up at once in the seconds and nanoseconds of that same result. A broken queue pointer shows up as results delivered out of order, or as a head result that changes while it waits. Overflow is checked exactly at the fifth unread result.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

  localparam logic [15:0] ETY_PTP   = 16'h88F7;
  localparam logic [15:0] ETY_CTAG  = 16'h8100;
  localparam logic [15:0] ETY_STAG  = 16'h88A8;
  localparam logic [15:0] ETY_IP4   = 16'h0800;
  localparam logic [15:0] ETY_IP6   = 16'h86DD;
  localparam logic [15:0] ETY_PPPOE = 16'h8864;
  localparam logic [15:0] ETY_LENMX = 16'h0600;
  localparam logic [15:0] PPP_IP4   = 16'h0021;
  localparam logic [15:0] PPP_IP6   = 16'h0057;
  localparam logic [15:0] UDP_EVT   = 16'd319;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

  typedef enum logic [3:0] {
    PS_IDLE, PS_MAC, PS_ETY, PS_TAG, PS_SNAP, PS_PPPOE,
    PS_IP4, PS_IP6, PS_UDP, PS_PTP, PS_HIT, PS_DROP
  } pstate_t;

  typedef struct packed {
    logic [47:0] sec;
    logic [31:0] ns;
  } tstamp_t;

  typedef struct packed {
    tstamp_t     ts;
    logic [3:0]  mtype;
    logic [15:0] seq;
  } ptp_result_t;

endpackage

// File: rtl/ptp_frame_parser.sv
module ptp_frame_parser
  import ptp_stamp_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int MAX_TAGS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_err,
  output logic        hit_o,
  output logic [3:0]  mtype_o,
  output logic [15:0] seq_o
);

  localparam int TAG_W = $clog2(MAX_TAGS + 1);

  pstate_t            st;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   hlen;
  logic [7:0]         hi;
  logic [TAG_W-1:0]   tags;
  logic               snap_seen;

  function automatic logic [7:0] snap_ref(input logic [CNT_W-1:0] i);
    if (i < 2) return 8'hAA;
    if (i == 2) return 8'h03;
    return 8'h00;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PS_IDLE;
      cnt       <= '0;
      hlen      <= '0;
      hi        <= '0;
      tags      <= '0;
      snap_seen <= 1'b0;
      hit_o     <= 1'b0;
      mtype_o   <= '0;
      seq_o     <= '0;
    end else begin
      hit_o <= 1'b0;
      if (in_valid) begin
        if (in_sof) begin
          st        <= PS_MAC;
          cnt       <= CNT_W'(1);
          tags      <= '0;
          snap_seen <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
          case (st)
            PS_MAC: if (cnt == CNT_W'(11)) begin st <= PS_ETY; cnt <= '0; end
            PS_ETY: begin
              if (cnt == '0) hi <= in_data;
              else begin
                cnt <= '0;
                if ({hi, in_data} == ETY_CTAG || {hi, in_data} == ETY_STAG) begin
                  if (tags == TAG_W'(MAX_TAGS)) st <= PS_DROP;
                  else begin tags <= tags + 1'b1; st <= PS_TAG; end
                end else if ({hi, in_data} == ETY_PTP)   st <= PS_PTP;
                else if ({hi, in_data} == ETY_IP4)       st <= PS_IP4;
                else if ({hi, in_data} == ETY_IP6)       st <= PS_IP6;
                else if ({hi, in_data} == ETY_PPPOE)     st <= PS_PPPOE;
                else if ({hi, in_data} < ETY_LENMX && !snap_seen) begin
                  st <= PS_SNAP; snap_seen <= 1'b1;
                end else st <= PS_DROP;
              end
            end
            PS_TAG: if (cnt == CNT_W'(1)) begin st <= PS_ETY; cnt <= '0; end
            PS_SNAP: begin
              if (in_data != snap_ref(cnt)) st <= PS_DROP;
              else if (cnt == CNT_W'(5)) begin st <= PS_ETY; cnt <= '0; end
            end
            PS_PPPOE: begin
              if (cnt == CNT_W'(6)) hi <= in_data;
              else if (cnt == CNT_W'(7)) begin
                cnt <= '0;
                if ({hi, in_data} == PPP_IP4)      st <= PS_IP4;
                else if ({hi, in_data} == PPP_IP6) st <= PS_IP6;
                else                               st <= PS_DROP;
              end
            end
            PS_IP4: begin
              if (cnt == '0) begin
                if (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5) st <= PS_DROP;
                hlen <= CNT_W'({in_data[3:0], 2'b00});
              end else if (cnt == CNT_W'(9) && in_data != PROTO_UDP) st <= PS_DROP;
              else if (cnt == hlen - 1'b1) begin st <= PS_UDP; cnt <= '0; end
            end
            PS_IP6: begin
              if (cnt == '0 && in_data[7:4] != 4'd6) st <= PS_DROP;
              else if (cnt == CNT_W'(6) && in_data != PROTO_UDP) st <= PS_DROP;
              else if (cnt == CNT_W'(39)) begin st <= PS_UDP; cnt <= '0; end
            end
            PS_UDP: begin
              if (cnt == CNT_W'(2)) hi <= in_data;
              else if (cnt == CNT_W'(3) && {hi, in_data} != UDP_EVT) st <= PS_DROP;
              else if (cnt == CNT_W'(7)) begin st <= PS_PTP; cnt <= '0; end
            end
            PS_PTP: begin
              if (cnt == '0) begin
                if (in_data[3:0] > 4'd3) st <= PS_DROP;
                mtype_o <= in_data[3:0];
              end else if (cnt == CNT_W'(30)) hi <= in_data;
              else if (cnt == CNT_W'(31)) begin
                seq_o <= {hi, in_data};
                st    <= PS_HIT;
              end
            end
            default: cnt <= cnt;
          endcase
        end
        if (in_eof) begin
          hit_o <= (st == PS_HIT) && !in_err && !in_sof;
          st    <= PS_IDLE;
        end
      end
    end
  end

  // R7: only event message types leave the parser
  a_r7_event_type: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (mtype_o <= 4'd3));
  // R9: a match is only reported after a clean frame end
  a_r9_clean_end: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(in_valid && in_eof && !in_err));

endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture
  import ptp_stamp_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  logic [47:0] tod_sec,
  input  logic [31:0] tod_ns,
  input  logic [31:0] lat_ns,
  output tstamp_t     ts_o
);

  tstamp_t adj;

  generate
    if (IS_TX) begin : g_add
      logic [32:0] sum;
      always_comb begin
        sum = {1'b0, tod_ns} + {1'b0, lat_ns};
        if (sum >= {1'b0, NS_PER_SEC}) begin
          adj.ns  = 32'(sum - {1'b0, NS_PER_SEC});
          adj.sec = tod_sec + 48'd1;
        end else begin
          adj.ns  = sum[31:0];
          adj.sec = tod_sec;
        end
      end
    end else begin : g_sub
      always_comb begin
        if (tod_ns >= lat_ns) begin
          adj.ns  = tod_ns - lat_ns;
          adj.sec = tod_sec;
        end else begin
          adj.ns  = tod_ns + (NS_PER_SEC - lat_ns);
          adj.sec = tod_sec - 48'd1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       ts_o <= '0;
    else if (take) ts_o <= adj;
  end

  // R8: corrected nanoseconds stay inside one second
  a_r8_ns_range: assert property (@(posedge clk) disable iff (rst)
    ts_o.ns < NS_PER_SEC);

endmodule

// File: rtl/ptp_res_fifo.sv
module ptp_res_fifo #(
  parameter int W     = 100,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         ready_i,
  output logic         valid_o,
  output logic         full_o,
  output logic [W-1:0] dout_o
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          pop;

  assign valid_o = (count != '0);
  assign full_o  = (count == (AW+1)'(DEPTH));
  assign pop     = valid_o && ready_i;
  assign dout_o  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  // R10: waiting head result is held
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(dout_o)));
  // R10: occupancy never exceeds the depth
  a_r10_bound: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  // R11: nothing is written into a full queue
  a_r11_no_push_full: assert property (@(posedge clk) disable iff (rst)
    (full_o && !pop) |-> !push);

endmodule

// File: rtl/ptp_stamp_unit.sv
module ptp_stamp_unit
  import ptp_stamp_pkg::*;
#(
  parameter bit IS_TX      = 1'b1,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] lat_ns,
  input  logic [47:0] tod_sec,
  input  logic [31:0] tod_ns,
  input  logic        fr_valid,
  input  logic [7:0]  fr_data,
  input  logic        fr_sof,
  input  logic        fr_eof,
  input  logic        fr_err,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [47:0] res_sec,
  output logic [31:0] res_ns,
  output logic [3:0]  res_type,
  output logic [15:0] res_seq,
  output logic        res_ovf
);

  localparam int RW = $bits(ptp_result_t);

  logic        hit, full;
  logic [3:0]  mtype;
  logic [15:0] seq;
  tstamp_t     ts;
  ptp_result_t wr_res, rd_res;

  ptp_frame_parser u_parse (
    .clk(clk), .rst(rst), .in_valid(fr_valid), .in_data(fr_data),
    .in_sof(fr_sof), .in_eof(fr_eof), .in_err(fr_err),
    .hit_o(hit), .mtype_o(mtype), .seq_o(seq)
  );

  ptp_ts_capture #(.IS_TX(IS_TX)) u_cap (
    .clk(clk), .rst(rst), .take(fr_valid && fr_sof),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .lat_ns(lat_ns), .ts_o(ts)
  );

  assign wr_res = '{ts: ts, mtype: mtype, seq: seq};

  ptp_res_fifo #(.W(RW), .DEPTH(FIFO_DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(hit && !full), .din(wr_res),
    .ready_i(res_ready), .valid_o(res_valid), .full_o(full), .dout_o(rd_res)
  );

  assign res_sec  = rd_res.ts.sec;
  assign res_ns   = rd_res.ts.ns;
  assign res_type = rd_res.mtype;
  assign res_seq  = rd_res.seq;

  always_ff @(posedge clk) begin
    if (rst)              res_ovf <= 1'b0;
    else if (hit && full) res_ovf <= 1'b1;
  end

  // R11: overflow flag is sticky until reset
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    res_ovf |=> res_ovf);

endmodule

// File: tb/ptp_stamp_unit_test.sv
module ptp_stamp_unit_test;

  localparam int  LAT = 300;
  localparam longint NSS = 64'd1_000_000_000;

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic [31:0] lat_ns = LAT;
  logic [47:0] tod_sec = 0;
  logic [31:0] tod_ns = 0;
  logic fr_valid = 0, fr_sof = 0, fr_eof = 0, fr_err = 0;
  logic [7:0] fr_data = 0;
  logic t_rdy = 0, r_rdy = 0;
  logic t_valid, r_valid, t_ovf, r_ovf;
  logic [47:0] t_sec, r_sec;
  logic [31:0] t_ns, r_ns;
  logic [3:0] t_type, r_type;
  logic [15:0] t_seq, r_seq;

  ptp_stamp_unit #(.IS_TX(1'b1)) uut (
    .clk(clk), .rst(rst), .lat_ns(lat_ns), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .fr_valid(fr_valid), .fr_data(fr_data), .fr_sof(fr_sof), .fr_eof(fr_eof),
    .fr_err(fr_err), .res_valid(t_valid), .res_ready(t_rdy), .res_sec(t_sec),
    .res_ns(t_ns), .res_type(t_type), .res_seq(t_seq), .res_ovf(t_ovf));

  ptp_stamp_unit #(.IS_TX(1'b0)) uut_rx (
    .clk(clk), .rst(rst), .lat_ns(lat_ns), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .fr_valid(fr_valid), .fr_data(fr_data), .fr_sof(fr_sof), .fr_eof(fr_eof),
    .fr_err(fr_err), .res_valid(r_valid), .res_ready(r_rdy), .res_sec(r_sec),
    .res_ns(r_ns), .res_type(r_type), .res_seq(r_seq), .res_ovf(r_ovf));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // vector table: kind, message type, sequence, nanoseconds, expect match
  localparam int NV = 16;
  localparam int V_KIND [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 0, 0};
  localparam int V_MT   [NV] = '{0, 1, 2, 0, 0, 3, 0, 1, 0, 2, 3, 0, 0, 0, 8, 11};
  localparam int V_SEQ  [NV] = '{'h0101, 'h0202, 'h0303, 'h0404, 'h0505, 'h0606,
                                 'h0707, 'h0808, 'h0909, 'h0A0A, 'h0B0B, 'h0C0C,
                                 'h0D0D, 'h0E0E, 'h0F0F, 'h1010};
  localparam int V_NS   [NV] = '{500000000, 100, 999999900, 1000, 2000, 3000, 4000,
                                 5000, 6000, 7000, 8000, 9000, 1000, 1000, 1000, 1000};
  localparam bit V_EXP  [NV] = '{1, 1, 1, 0, 1, 1, 0, 1, 0, 1, 1, 1, 0, 0, 0, 0};

  function automatic string req_of(input int kind, input int mt);
    if (mt > 3) return "R7";
    case (kind)
      0: return "R1";
      1, 2, 3: return "R2";
      4, 5, 6: return "R3";
      7, 8: return "R4";
      9, 10: return "R5";
      11, 12: return "R6";
      default: return "R7";
    endcase
  endfunction

  logic [7:0] fb [0:159];
  int fl;

  task automatic pb(input logic [7:0] b); fb[fl] = b; fl++; endtask
  task automatic pety(input logic [15:0] e); pb(e[15:8]); pb(e[7:0]); endtask
  task automatic pudp(input logic [15:0] port);
    pety(16'd319); pety(port); pety(16'd52); pety(16'd0);
  endtask
  task automatic pip4(input int ihl, input logic [15:0] port);
    pb({4'd4, 4'(ihl)});
    for (int j = 1; j < ihl * 4; j++) pb(j == 9 ? 8'd17 : 8'h00);
    pudp(port);
  endtask
  task automatic pip6(input logic [7:0] nh);
    for (int j = 0; j < 40; j++) pb(j == 0 ? 8'h60 : (j == 6 ? nh : 8'h00));
    pudp(16'd319);
  endtask

  task automatic build(input int kind, input int mt, input int sq);
    fl = 0;
    for (int j = 0; j < 12; j++) pb(8'(8'h10 + j));
    case (kind)
      0: pety(16'h88F7);
      1: begin pety(16'h8100); pety(16'h0005); pety(16'h88F7); end
      2: begin pety(16'h88A8); pety(16'h0006); pety(16'h8100); pety(16'h0005); pety(16'h88F7); end
      3: begin for (int j = 0; j < 3; j++) begin pety(16'h8100); pety(16'h0001); end pety(16'h88F7); end
      4: begin pety(16'h0800); pip4(5, 16'd319); end
      5: begin pety(16'h0800); pip4(6, 16'd319); end
      6: begin pety(16'h0800); pip4(5, 16'd320); end
      7: begin pety(16'h86DD); pip6(8'd17); end
      8: begin pety(16'h86DD); pip6(8'd0); end
      9: begin pety(16'h8864); pety(16'h1100); pety(16'h0001); pety(16'h0040);
               pety(16'h0021); pip4(5, 16'd319); end
      10: begin pety(16'h8864); pety(16'h1100); pety(16'h0001); pety(16'h0040);
                pety(16'h0057); pip6(8'd17); end
      11: begin pety(16'h0040); pety(16'hAAAA); pety(16'h0300); pety(16'h0000);
                pety(16'h0800); pip4(5, 16'd319); end
      12: begin pety(16'h0040); pety(16'hAAAA); pety(16'h0300); pety(16'h0001);
                pety(16'h0800); pip4(5, 16'd319); end
      default: pety(16'h0806);
    endcase
    pb({4'h0, 4'(mt)}); pb(8'h02);
    for (int j = 2; j < 30; j++) pb(8'h00);
    pety(16'(sq));
    for (int j = 0; j < 8; j++) pb(8'hC0 + 8'(j));
  endtask

  task automatic send(input int len, input bit err);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      fr_valid = 1; fr_data = fb[i];
      fr_sof = (i == 0); fr_eof = (i == len - 1); fr_err = err && (i == len - 1);
      if (i == 1) begin tod_sec = tod_sec + 77; tod_ns = 12345; end
    end
    @(negedge clk);
    fr_valid = 0; fr_sof = 0; fr_eof = 0; fr_err = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_both();
    t_rdy = 1; r_rdy = 1;
    @(negedge clk);
    t_rdy = 0; r_rdy = 0;
  endtask

  task automatic do_reset();
    rst = 1; repeat (3) @(negedge clk); rst = 0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint es, en;
    do_reset();
    chk(t_valid == 0 && r_valid == 0, "R12", "valid after reset", t_valid, 0);
    chk(t_ovf == 0 && r_ovf == 0, "R12", "ovf after reset", t_ovf, 0);

    for (int v = 0; v < NV; v++) begin
      string rq;
      rq = req_of(V_KIND[v], V_MT[v]);
      build(V_KIND[v], V_MT[v], V_SEQ[v]);
      tod_sec = 48'(1000 + v); tod_ns = V_NS[v];
      send(fl, 0);
      chk(t_valid == V_EXP[v], rq, $sformatf("tx match v%0d", v), t_valid, V_EXP[v]);
      chk(r_valid == V_EXP[v], rq, $sformatf("rx match v%0d", v), r_valid, V_EXP[v]);
      if (V_EXP[v] && t_valid && r_valid) begin
        chk(t_type == 4'(V_MT[v]) && r_type == 4'(V_MT[v]), rq, "type", t_type, V_MT[v]);
        chk(t_seq == 16'(V_SEQ[v]) && r_seq == 16'(V_SEQ[v]), rq, "seq", t_seq, V_SEQ[v]);
        es = 1000 + v; en = V_NS[v] + LAT;
        if (en >= NSS) begin en -= NSS; es++; end
        chk(t_sec == 48'(es) && t_ns == 32'(en), "R8", "tx stamp",
            {t_sec[15:0], t_ns}, {es[15:0], en[31:0]});
        es = 1000 + v; en = V_NS[v] - LAT;
        if (en < 0) begin en += NSS; es--; end
        chk(r_sec == 48'(es) && r_ns == 32'(en), "R8", "rx stamp",
            {r_sec[15:0], r_ns}, {es[15:0], en[31:0]});
        pop_both();
      end
    end

    // R9: error-terminated and truncated frames
    build(0, 0, 'h2222); send(fl, 1);
    chk(t_valid == 0 && r_valid == 0, "R9", "error frame", t_valid, 0);
    build(0, 0, 'h2323); send(30, 0);
    chk(t_valid == 0 && r_valid == 0, "R9", "truncated frame", t_valid, 0);

    // R10 / R11: fill the queue without reading
    for (int k = 0; k < 5; k++) begin
      build(0, 1, 'h100 + k); tod_sec = 48'(5000 + k); tod_ns = 1000; send(fl, 0);
      if (k == 3) chk(t_ovf == 0, "R11", "no ovf at four", t_ovf, 0);
    end
    chk(t_valid == 1 && t_seq == 16'h0100, "R10", "head held", t_seq, 'h100);
    chk(t_ovf == 1 && r_ovf == 1, "R11", "ovf at fifth", t_ovf, 1);
    for (int k = 0; k < 4; k++) begin
      chk(t_valid == 1 && t_seq == 16'(16'h100 + k), "R10", "order", t_seq, 'h100 + k);
      pop_both();
    end
    chk(t_valid == 0, "R11", "dropped not stored", t_valid, 0);
    build(0, 2, 'h3333); send(fl, 0);
    chk(t_ovf == 1 && t_valid == 1, "R11", "ovf sticky", t_ovf, 1);
    pop_both();
    do_reset();
    chk(t_ovf == 0 && t_valid == 0, "R12", "ovf cleared by reset", t_ovf, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule